// File: doc/BRIEF.md
# Shared Byte Memory with Atomic Read-Modify-Write

This block is a small, byte-wide shared memory used by several requesters at once. Each requester has its own request channel. On that channel it can ask for a plain load, a plain store, or one of three atomic updates: set-top-bit (test-and-set), swap, or add. A rotating-priority arbiter chooses one requester at a time to serve.

Every operation returns the byte that the addressed location held before the operation. It also returns two condition flags computed from that prior byte. A requester builds a spin lock by repeating set-top-bit until the returned byte has a clear top bit. It can also use add to keep a shared counter that no other requester can corrupt.

An atomic update takes two granted cycles: a read cycle, then a write-back cycle. Between the two, the memory is held for the owning requester. No other port can read or write the array until the write-back has finished.

Top module: `atomic_mem`

## Requirements
- R1: After reset every byte reads as zero, no response valid is high, and the first grant goes to port 0.
- R2: A load (op code 0) completes in the same cycle it is granted, leaves memory unchanged and returns the stored byte.
- R3: A store (op code 1) completes in the cycle it is granted, writes the request data and returns the byte held before.
- R4: Set-top-bit (op code 2) writes the prior byte with its most significant bit forced to 1 and returns the prior byte.
- R5: With every response, the negative flag equals the most significant bit of the returned prior byte, and the zero flag is 1 exactly when that byte is all zeros.
- R6: Swap (op code 3) writes the request data and returns the prior byte as one indivisible step.
- R7: Add (op code 4) writes the prior byte plus the request data, modulo 2^DATA_W, and returns the prior byte.
- R8: An atomic op (codes 2, 3 and 4) is accepted one cycle after it is first granted. In the cycle before its acceptance, no port is accepted.
- R9: Priority rotates: after port k completes, the search for the next grant starts at port k+1, wrapping around to port 0.
- R10: A response valid pulses for exactly one cycle, in the cycle after the request handshake (valid and ready both high) of that port.
- R11: At most one port sees ready in any cycle, so concurrent atomic adds never lose an update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_PORTS | Per-port request valid; held until ready |
| req_ready | output | NUM_PORTS | Per-port acceptance; the operation completes in this cycle |
| req_op | input | 3*NUM_PORTS | Per-port op code (0 load, 1 store, 2 set-top-bit, 3 swap, 4 add) |
| req_addr | input | ADDR_W*NUM_PORTS | Per-port byte address |
| req_wdata | input | DATA_W*NUM_PORTS | Per-port store, swap or add operand |
| rsp_valid | output | NUM_PORTS | Per-port one-cycle response strobe |
| rsp_rdata | output | DATA_W*NUM_PORTS | Per-port prior byte |
| rsp_neg | output | NUM_PORTS | Per-port negative flag |
| rsp_zero | output | NUM_PORTS | Per-port zero flag |

## Verification
Every address is stored, loaded, set, swapped and added with values derived from the address. This separates a wrong write path from a wrong returned byte, because every response is compared with a model of the prior contents. Two dedicated sequences cover the flags: set-top-bit on a zero byte, then on a byte whose top bit is already set, and an add that wraps past the top of the range. These show a correct zero flag, a correct negative flag and correct carry dropping. Three ports then issue interleaved adds to one byte. A correct final sum, together with distinct returned values, can only come from a lock that is truly exclusive. A simultaneous start from reset shows the grant order.

// File: rtl/atm_pkg.sv
package atm_pkg;
   localparam int OP_W = 3;

   typedef enum logic [OP_W-1:0] {
      OP_LOAD  = 3'd0,
      OP_STORE = 3'd1,
      OP_SETTOP = 3'd2,
      OP_SWAP  = 3'd3,
      OP_ADD   = 3'd4
   } atm_op_e;

   function automatic logic op_is_atomic(input atm_op_e op);
      return (op == OP_SETTOP) || (op == OP_SWAP) || (op == OP_ADD);
   endfunction
endpackage

// File: rtl/atm_rr_arbiter.sv
module atm_rr_arbiter #(
   parameter int NUM_REQ = 3,
   parameter int IDX_W   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_REQ-1:0] req,
   input  logic               advance,
   input  logic [IDX_W-1:0]   done_idx,
   output logic               gnt_any,
   output logic [IDX_W-1:0]   gnt_idx
);
   logic [IDX_W-1:0] ptr_q;

   always_comb begin
      gnt_any = 1'b0;
      gnt_idx = '0;
      for (int k = 0; k < NUM_REQ; k++) begin
         int cand;
         cand = (int'(ptr_q) + k) % NUM_REQ;
         if (!gnt_any && req[cand]) begin
            gnt_any = 1'b1;
            gnt_idx = IDX_W'(cand);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (advance) begin
         if (int'(done_idx) == NUM_REQ - 1) ptr_q <= '0;
         else                                 ptr_q <= done_idx + IDX_W'(1);
      end
   end
endmodule

// File: rtl/atm_modify.sv
module atm_modify
   import atm_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  atm_op_e           op,
   input  logic [DATA_W-1:0] prior,
   input  logic [DATA_W-1:0] operand,
   output logic [DATA_W-1:0] new_val,
   output logic              do_write,
   output logic              flag_neg,
   output logic              flag_zero
);
   localparam logic [DATA_W-1:0] TOP_BIT = {1'b1, {(DATA_W-1){1'b0}}};

   always_comb begin
      new_val  = prior;
      do_write = 1'b0;
      case (op)
         OP_STORE:  begin new_val = operand;         do_write = 1'b1; end
         OP_SETTOP: begin new_val = prior | TOP_BIT; do_write = 1'b1; end
         OP_SWAP:   begin new_val = operand;         do_write = 1'b1; end
         OP_ADD:    begin new_val = prior + operand; do_write = 1'b1; end
         default:   begin new_val = prior;           do_write = 1'b0; end
      endcase
      flag_neg  = prior[DATA_W-1];
      flag_zero = (prior == '0);
   end
endmodule

// File: rtl/atm_store.sv
module atm_store #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   assign rd_data = cells[rd_addr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
      end else if (wr_en) begin
         cells[wr_addr] <= wr_data;
      end
   end
endmodule

// File: rtl/atomic_mem.sv
module atomic_mem
   import atm_pkg::*;
#(
   parameter int NUM_PORTS = 3,
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_PORTS-1:0]          req_valid,
   output logic [NUM_PORTS-1:0]          req_ready,
   input  logic [NUM_PORTS*OP_W-1:0]     req_op,
   input  logic [NUM_PORTS*ADDR_W-1:0]   req_addr,
   input  logic [NUM_PORTS*DATA_W-1:0]   req_wdata,
   output logic [NUM_PORTS-1:0]          rsp_valid,
   output logic [NUM_PORTS*DATA_W-1:0]   rsp_rdata,
   output logic [NUM_PORTS-1:0]          rsp_neg,
   output logic [NUM_PORTS-1:0]          rsp_zero
);
   localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

   generate
      if (NUM_PORTS < 2) begin : g_chk_ports
         $error("atomic_mem: NUM_PORTS must be at least 2");
      end
      if (DATA_W < 2) begin : g_chk_data
         $error("atomic_mem: DATA_W must be at least 2");
      end
      if (ADDR_W < 1 || ADDR_W > 10) begin : g_chk_addr
         $error("atomic_mem: ADDR_W must lie in 1..10");
      end
   endgenerate

   // per-port request fields
   logic [OP_W-1:0]   p_op    [NUM_PORTS];
   logic [ADDR_W-1:0] p_addr  [NUM_PORTS];
   logic [DATA_W-1:0] p_wdata [NUM_PORTS];

   genvar gp;
   generate
      for (gp = 0; gp < NUM_PORTS; gp++) begin : g_unpack
         assign p_op[gp]    = req_op[gp*OP_W +: OP_W];
         assign p_addr[gp]  = req_addr[gp*ADDR_W +: ADDR_W];
         assign p_wdata[gp] = req_wdata[gp*DATA_W +: DATA_W];
      end
   endgenerate

   // arbitration
   logic             gnt_any;
   logic [IDX_W-1:0] gnt_idx;
   logic             complete;
   logic [IDX_W-1:0] sel;

   atm_rr_arbiter #(.NUM_REQ(NUM_PORTS), .IDX_W(IDX_W)) u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req_valid),
      .advance  (complete),
      .done_idx (sel),
      .gnt_any  (gnt_any),
      .gnt_idx  (gnt_idx)
   );

   // lock state held between read and write-back of an atomic op
   logic              locked_q;
   logic [IDX_W-1:0]  lk_port_q;
   atm_op_e           lk_op_q;
   logic [ADDR_W-1:0] lk_addr_q;
   logic [DATA_W-1:0] lk_wdata_q;
   logic [DATA_W-1:0] lk_prior_q;

   atm_op_e           gnt_op;
   atm_op_e           cur_op;
   logic [DATA_W-1:0] cur_wdata;
   logic [ADDR_W-1:0] cur_addr;
   logic [DATA_W-1:0] mem_rd;
   logic [DATA_W-1:0] prior;
   logic              start_atomic;

   assign gnt_op    = atm_op_e'(p_op[gnt_idx]);
   assign sel       = locked_q ? lk_port_q  : gnt_idx;
   assign cur_op    = locked_q ? lk_op_q    : gnt_op;
   assign cur_wdata = locked_q ? lk_wdata_q : p_wdata[gnt_idx];
   assign cur_addr  = locked_q ? lk_addr_q  : p_addr[gnt_idx];
   assign prior     = locked_q ? lk_prior_q : mem_rd;

   assign start_atomic = !locked_q && gnt_any && op_is_atomic(gnt_op);
   assign complete     = locked_q || (gnt_any && !op_is_atomic(gnt_op));

   // datapath
   logic [DATA_W-1:0] new_val;
   logic              do_write;
   logic              f_neg;
   logic              f_zero;

   atm_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_addr (p_addr[gnt_idx]),
      .rd_data (mem_rd),
      .wr_en   (complete && do_write),
      .wr_addr (cur_addr),
      .wr_data (new_val)
   );

   atm_modify #(.DATA_W(DATA_W)) u_mod (
      .op        (cur_op),
      .prior     (prior),
      .operand   (cur_wdata),
      .new_val   (new_val),
      .do_write  (do_write),
      .flag_neg  (f_neg),
      .flag_zero (f_zero)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         locked_q   <= 1'b0;
         lk_port_q  <= '0;
         lk_op_q    <= OP_LOAD;
         lk_addr_q  <= '0;
         lk_wdata_q <= '0;
         lk_prior_q <= '0;
      end else if (start_atomic) begin
         locked_q   <= 1'b1;
         lk_port_q  <= gnt_idx;
         lk_op_q    <= gnt_op;
         lk_addr_q  <= p_addr[gnt_idx];
         lk_wdata_q <= p_wdata[gnt_idx];
         lk_prior_q <= mem_rd;
      end else if (locked_q) begin
         locked_q   <= 1'b0;
      end
   end

   // per-port acceptance and response registers
   generate
      for (gp = 0; gp < NUM_PORTS; gp++) begin : g_port
         logic hit;
         assign hit           = complete && (sel == IDX_W'(gp));
         assign req_ready[gp] = hit;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rsp_valid[gp]                  <= 1'b0;
               rsp_rdata[gp*DATA_W +: DATA_W] <= '0;
               rsp_neg[gp]                    <= 1'b0;
               rsp_zero[gp]                   <= 1'b0;
            end else begin
               rsp_valid[gp] <= hit;
               if (hit) begin
                  rsp_rdata[gp*DATA_W +: DATA_W] <= prior;
                  rsp_neg[gp]                    <= f_neg;
                  rsp_zero[gp]                   <= f_zero;
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/atm_checker.sv
module atm_checker
   import atm_pkg::*;
#(
   parameter int NUM_PORTS = 3,
   parameter int DATA_W    = 8
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [NUM_PORTS-1:0]        req_valid,
   input logic [NUM_PORTS-1:0]        req_ready,
   input logic [NUM_PORTS*OP_W-1:0]   req_op,
   input logic [NUM_PORTS-1:0]        rsp_valid,
   input logic [NUM_PORTS*DATA_W-1:0] rsp_rdata,
   input logic [NUM_PORTS-1:0]        rsp_neg,
   input logic [NUM_PORTS-1:0]        rsp_zero
);
   p_single_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(req_ready));

   genvar gp;
   generate
      for (gp = 0; gp < NUM_PORTS; gp++) begin : g_chk
         logic is_atom;
         assign is_atom = op_is_atomic(atm_op_e'(req_op[gp*OP_W +: OP_W]));

         p_rsp_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[gp] && req_ready[gp]) |=> rsp_valid[gp]);

         p_rsp_has_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_valid[gp] |-> $past(req_valid[gp] && req_ready[gp]));

         p_atomic_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[gp] && req_ready[gp] && is_atom)
               |-> ($past(req_valid[gp]) && ($past(req_ready) == '0)));

         p_flag_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_valid[gp] |-> ((rsp_neg[gp] == rsp_rdata[gp*DATA_W + DATA_W - 1])
                               && (rsp_zero[gp] == (rsp_rdata[gp*DATA_W +: DATA_W] == '0))));
      end
   endgenerate
endmodule

bind atomic_mem atm_checker #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_op    (req_op),
   .rsp_valid (rsp_valid),
   .rsp_rdata (rsp_rdata),
   .rsp_neg   (rsp_neg),
   .rsp_zero  (rsp_zero)
);

// File: tb/sim_atomic_mem.sv
`timescale 1ns/1ps
module sim_atomic_mem;
   localparam int NP = 3;
   localparam int AW = 4;
   localparam int DW = 8;
   localparam int OW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [NP-1:0]    req_valid;
   logic [NP-1:0]    req_ready;
   logic [NP*OW-1:0] req_op;
   logic [NP*AW-1:0] req_addr;
   logic [NP*DW-1:0] req_wdata;
   logic [NP-1:0]    rsp_valid;
   logic [NP*DW-1:0] rsp_rdata;
   logic [NP-1:0]    rsp_neg;
   logic [NP-1:0]    rsp_zero;

   logic          b_valid [NP];
   logic [OW-1:0] b_op    [NP];
   logic [AW-1:0] b_addr  [NP];
   logic [DW-1:0] b_wd    [NP];

   always_comb begin
      for (int p = 0; p < NP; p++) begin
         req_valid[p]            = b_valid[p];
         req_op[p*OW +: OW]      = b_op[p];
         req_addr[p*AW +: AW]    = b_addr[p];
         req_wdata[p*DW +: DW]   = b_wd[p];
      end
   end

   atomic_mem #(.NUM_PORTS(NP), .ADDR_W(AW), .DATA_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .rsp_neg(rsp_neg), .rsp_zero(rsp_zero)
   );

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   int multi_ready = 0;
   bit finished = 0;
   int done_at [NP];
   logic [DW-1:0] model [1<<AW];

   always @(posedge clk) cyc <= cyc + 1;
   always @(negedge clk) if (rst_n && $countones(req_ready) > 1) multi_ready++;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic do_op(input int p, input logic [2:0] op, input logic [AW-1:0] a,
                        input logic [DW-1:0] wd, output logic [DW-1:0] old,
                        output logic n, output logic z, output int waits,
                        output bit rsp_ok);
      bit got;
      @(negedge clk);
      b_valid[p] = 1'b1; b_op[p] = op; b_addr[p] = a; b_wd[p] = wd;
      waits = 0;
      do begin
         #1 got = req_ready[p];
         if (!got) begin @(negedge clk); waits++; end
      end while (!got);
      @(negedge clk);
      b_valid[p] = 1'b0;
      done_at[p] = cyc;
      rsp_ok = rsp_valid[p];
      old = rsp_rdata[p*DW +: DW];
      n = rsp_neg[p];
      z = rsp_zero[p];
      @(negedge clk);
      rsp_ok = rsp_ok && !rsp_valid[p];
   endtask

   // single-port operation checked against the model
   task automatic op_chk(input int p, input logic [2:0] op, input logic [AW-1:0] a,
                         input logic [DW-1:0] wd, input string tag);
      logic [DW-1:0] old, prior, nxt;
      logic n, z;
      int w;
      bit ok;
      prior = model[a];
      do_op(p, op, a, wd, old, n, z, w, ok);
      case (op)
         3'd1: nxt = wd;
         3'd2: nxt = prior | 8'h80;
         3'd3: nxt = wd;
         3'd4: nxt = DW'((int'(prior) + int'(wd)) % 256);
         default: nxt = prior;
      endcase
      model[a] = nxt;
      chk(old == prior, tag, old, prior);
      chk(ok, "R10 single-cycle response", ok, 1);
      chk(n == prior[DW-1] && z == (prior == 0), "R5 flags", {n, z}, {prior[DW-1], prior == 0});
      chk(w == ((op >= 3'd2 && op <= 3'd4) ? 1 : 0), "R8 accept latency", w, (op >= 3'd2 && op <= 3'd4));
   endtask

   task automatic add_worker(input int p, input int reps, inout bit [255:0] seen, inout int dup);
      logic [DW-1:0] old; logic n, z; int w; bit ok;
      for (int i = 0; i < reps; i++) begin
         do_op(p, 3'd4, 4'd5, DW'(p + 1), old, n, z, w, ok);
         if (seen[old]) dup++;
         seen[old] = 1'b1;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         fails++; checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int p = 0; p < NP; p++) begin
         b_valid[p] = 0; b_op[p] = 0; b_addr[p] = 0; b_wd[p] = 0; done_at[p] = 0;
      end
      for (int a = 0; a < (1<<AW); a++) model[a] = '0;
      repeat (3) @(negedge clk);
      chk(rsp_valid == '0, "R1 no response in reset", rsp_valid, 0);
      rst_n = 1'b1;

      // R1 / R9: all ports start together with loads; order must be 0,1,2
      begin
         logic [DW-1:0] o0, o1, o2; logic n0, n1, n2, z0, z1, z2; int w0, w1, w2; bit k0, k1, k2;
         fork
            do_op(0, 3'd0, 4'd0, 8'h0, o0, n0, z0, w0, k0);
            do_op(1, 3'd0, 4'd1, 8'h0, o1, n1, z1, w1, k1);
            do_op(2, 3'd0, 4'd2, 8'h0, o2, n2, z2, w2, k2);
         join
         chk(done_at[0] < done_at[1] && done_at[1] < done_at[2], "R9 round-robin order",
             done_at[0]*100 + done_at[1]*10 + done_at[2], 0);
         chk(w0 == 0, "R1 first grant to port 0", w0, 0);
         chk(o0 == 0 && o1 == 0 && o2 == 0, "R1 memory cleared", {o0, o1, o2}, 0);
      end
      for (int a = 0; a < (1<<AW); a++) op_chk(a % NP, 3'd0, AW'(a), 8'h0, "R1 reset contents");

      // sweep every address through every op
      for (int a = 0; a < (1<<AW); a++) begin
         logic [DW-1:0] v;
         int p;
         p = a % NP;
         v = DW'(a * 17 + 3);
         op_chk(p, 3'd1, AW'(a), v, "R3 store returns prior");
         op_chk((p+1) % NP, 3'd0, AW'(a), 8'h0, "R2 load returns stored");
         op_chk(p, 3'd2, AW'(a), 8'h0, "R4 set-top-bit returns prior");
         op_chk((p+2) % NP, 3'd0, AW'(a), 8'h0, "R4 top bit now set");
         op_chk(p, 3'd3, AW'(a), ~v, "R6 swap returns prior");
         op_chk((p+1) % NP, 3'd4, AW'(a), DW'(a + 1), "R7 add returns prior");
         op_chk(p, 3'd0, AW'(a), 8'h0, "R7 sum stored");
      end

      // flag corner cases and add wrap-around
      op_chk(0, 3'd1, 4'd9, 8'h00, "R3 clear byte");
      op_chk(1, 3'd2, 4'd9, 8'h00, "R5 set-top-bit on zero byte");
      op_chk(2, 3'd2, 4'd9, 8'h00, "R5 set-top-bit on taken byte");
      op_chk(0, 3'd1, 4'd10, 8'hF0, "R3 store high byte");
      op_chk(1, 3'd4, 4'd10, 8'h20, "R7 add wraps");
      op_chk(2, 3'd0, 4'd10, 8'h00, "R7 wrapped result");

      // contention: three ports add to one byte concurrently
      begin
         bit [255:0] seen;
         int dup;
         logic [DW-1:0] fin; logic n, z; int w; bit ok;
         seen = '0; dup = 0;
         op_chk(0, 3'd1, 4'd5, 8'h00, "R3 clear counter");
         fork
            add_worker(0, 10, seen, dup);
            add_worker(1, 10, seen, dup);
            add_worker(2, 10, seen, dup);
         join
         do_op(0, 3'd0, 4'd5, 8'h0, fin, n, z, w, ok);
         chk(fin == 8'd60, "R11 concurrent add total", fin, 60);
         chk(dup == 0, "R8 no two atomics saw same prior", dup, 0);
         chk(multi_ready == 0, "R11 single ready per cycle", multi_ready, 0);
         model[5] = 8'd60;
      end

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule